// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block divides a fast input clock by an integer N and emits one single-cycle pulse per N input cycles, for use as the feedback path of a frequency synthesizer toward its phase detector. Division is built from a dual-modulus prescaler (P or P+1), a 6-bit swallow count A and a 12-bit main count B. In each output period the prescaler runs at P+1 for the first A of its B cycles and at P for the remaining B−A, so N = B·P + A. This gives unit steps in N rather than steps of P.

A new setting (prescaler select, A and B) is captured on a load strobe and held in shadow registers. It only reaches the running counters at the next period boundary, so a period that is already under way always finishes with its old ratio. A synchronous counter reset and a power-down input both park the counters in their period-start state. Power-down also drops the modulus-control output.

Top module: `dual_mod_divider`

## Requirements
- R1: The number of rising input-clock edges from one output pulse to the next equals B·P + A for the setting in force in that period.
- R2: The output pulse is high for exactly one input-clock cycle per period.
- R3: The 2-bit prescaler select picks the modulus pair: 0 gives 8/9, 1 gives 16/17, 2 gives 32/33, 3 gives 64/65.
- R4: A legal setting has A in 0..63, B in 3..4095 and B ≥ A. Loading only legal settings keeps the running swallow count at or below the running main count.
- R5: Within each period the modulus-control output is high for exactly A·(P+1) input cycles, namely the first A prescaler cycles, each of which lasts P+1 inputs. It falls only at a prescaler cycle boundary.
- R6: A setting captured by the load strobe in mid-period does not change the period in progress. It applies from the following period onward.
- R7: While counter reset is high, no pulse is produced and the counters hold the period-start state of the stored setting. After release, the first pulse comes N−1 rising edges later.
- R8: While power-down is high, no pulse is produced and modulus control stays low. A setting loaded during power-down is in force for the first period after release, whose pulse comes N−1 rising edges later.
- R9: Asynchronous reset keeps both outputs low and installs the setting B=3, A=0, select 0, which gives N=24.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock being divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 2 | Prescaler modulus select, captured on load |
| a_in | input | 6 | Swallow count A, captured on load |
| b_in | input | 12 | Main count B, captured on load |
| load | input | 1 | Captures psel, a_in and b_in into the shadow setting |
| cnt_rst | input | 1 | Holds the counters at period start |
| pdown | input | 1 | Power-down: holds the counters and forces modulus control low |
| div_pulse | output | 1 | One-cycle pulse marking the end of each period |
| mod_ctl | output | 1 | High while the prescaler divides by P+1 |

## Verification
On every cycle the assertions check that pulses never last two cycles and that loaded settings are legal. They also check that the swallow count never exceeds the main count, that modulus control falls only at prescaler boundaries, and that a held divider tracks the stored setting. The scenarios are needed for the ratio itself: counted edges between pulses against B·P + A, the A·(P+1) modulus-control duty, the old ratio surviving a mid-period load, and the N−1 restart distance after reset or power-down.

// File: rtl/dual_mod_divider.sv
module dual_mod_divider #(
  parameter int A_W   = 6,
  parameter int B_W   = 12,
  parameter int SEL_W = 2,
  parameter int PMIN  = 8,
  parameter int B_RST = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] psel,
  input  logic [A_W-1:0]   a_in,
  input  logic [B_W-1:0]   b_in,
  input  logic             load,
  input  logic             cnt_rst,
  input  logic             pdown,
  output logic             div_pulse,
  output logic             mod_ctl
);
  localparam int PMAX = PMIN << ((1 << SEL_W) - 1);
  localparam int PC_W = $clog2(PMAX) + 1;

  logic [A_W-1:0]   sh_a, a_cnt, a_nxt;
  logic [B_W-1:0]   sh_b, b_cnt;
  logic [SEL_W-1:0] sh_ps;
  logic [PC_W-1:0]  sh_p, cur_p, pre, start_pre;
  logic             hold, pre_end, last;

  assign hold      = cnt_rst | pdown;
  assign sh_p      = PC_W'(PMIN) << sh_ps;
  assign start_pre = (sh_a != '0) ? sh_p : sh_p - 1'b1;
  assign pre_end   = (pre == '0);
  assign last      = pre_end && (b_cnt == B_W'(1));
  assign a_nxt     = (a_cnt != '0) ? a_cnt - 1'b1 : a_cnt;

  assign div_pulse = !hold && last;
  assign mod_ctl   = !pdown && (a_cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_a  <= '0;
      sh_b  <= B_W'(B_RST);
      sh_ps <= '0;
    end else if (load) begin
      sh_a  <= a_in;
      sh_b  <= b_in;
      sh_ps <= psel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      b_cnt <= B_W'(B_RST);
      a_cnt <= '0;
      cur_p <= PC_W'(PMIN);
      pre   <= PC_W'(PMIN - 1);
    end else if (hold || last) begin
      b_cnt <= sh_b;
      a_cnt <= sh_a;
      cur_p <= sh_p;
      pre   <= start_pre;
    end else if (pre_end) begin
      b_cnt <= b_cnt - 1'b1;
      a_cnt <= a_nxt;
      pre   <= (a_nxt != '0) ? cur_p : cur_p - 1'b1;
    end else begin
      pre   <= pre - 1'b1;
    end
  end

  assert_single_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    div_pulse |=> !div_pulse);

  assert_legal_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (b_in >= B_W'(3)) && (b_in >= B_W'(a_in)));

  assert_swallow_le_main_R4: assert property (@(posedge clk) disable iff (!rst_n)
    B_W'(a_cnt) <= b_cnt);

  assert_modfall_at_boundary_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mod_ctl) && !pdown && !cnt_rst && !$past(pdown) && !$past(cnt_rst))
      |-> ($past(pre) == '0));

  assert_hold_parks_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_rst && !load) |=> (b_cnt == $past(sh_b)) && (a_cnt == $past(sh_a)));
endmodule

// File: tb/dual_mod_divider_test.sv
`timescale 1ns/1ps
module dual_mod_divider_test;
  logic        clk = 0, rst_n = 0, load = 0, cnt_rst = 0, pdown = 0;
  logic [1:0]  psel = 0;
  logic [5:0]  a_in = 0;
  logic [11:0] b_in = 0;
  logic        div_pulse, mod_ctl;
  int checks = 0, fails = 0, cur_n = 0;

  dual_mod_divider uut (.clk, .rst_n, .psel, .a_in, .b_in, .load, .cnt_rst,
                        .pdown, .div_pulse, .mod_ctl);

  always #2 clk = ~clk;

  function automatic int exp_n(int ps, int a, int b);
    return b * (8 << ps) + a;
  endfunction

  function automatic int exp_hi(int ps, int a);
    return a * ((8 << ps) + 1);
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic to_pulse(output int n, output int hi);
    n = 0; hi = 0;
    do begin
      @(negedge clk);
      n++;
      if (mod_ctl) hi++;
    end while (!div_pulse && n < 20000);
  endtask

  task automatic apply(int ps, int a, int b);
    int c, n, hi;
    c = 0;
    repeat (3) begin @(negedge clk); c++; end
    psel = 2'(ps); a_in = 6'(a); b_in = 12'(b); load = 1;
    @(negedge clk); c++;
    load = 0;
    to_pulse(n, hi);
    chk(c + n == cur_n, "R6 old ratio kept", c + n, cur_n);
    to_pulse(n, hi);
    chk(n == exp_n(ps, a, b), "R1/R3 period", n, exp_n(ps, a, b));
    chk(hi == exp_hi(ps, a), "R5 mod_ctl cycles", hi, exp_hi(ps, a));
    cur_n = exp_n(ps, a, b);
  endtask

  initial begin
    #700000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n, hi, seen, mhi;
    void'($urandom(32'd20240611));
    // R9: outputs low in reset
    seen = 0;
    repeat (4) begin @(negedge clk); if (div_pulse || mod_ctl) seen++; end
    chk(seen == 0, "R9 outputs in reset", seen, 0);
    rst_n = 1;
    to_pulse(n, hi);
    chk(n == 23, "R9 first pulse after reset", n, 23);
    to_pulse(n, hi);
    chk(n == 24, "R9 default ratio", n, 24);
    cur_n = 24;
    // R2: one-cycle pulse
    @(negedge clk);
    chk(div_pulse == 0, "R2 pulse width", div_pulse, 0);
    to_pulse(n, hi);
    // directed corners
    apply(0, 0, 3);
    apply(0, 5, 5);
    apply(1, 7, 9);
    apply(2, 0, 4);
    apply(3, 63, 63);
    apply(3, 3, 3);
    // constrained random legal settings (R4)
    for (int i = 0; i < 8; i++) begin
      int ps, a, b;
      ps = int'($urandom % 4);
      a  = int'($urandom % 32);
      b  = ((a > 3) ? a : 3) + int'($urandom % 17);
      apply(ps, a, b);
    end
    // R7: counter reset holds
    apply(2, 9, 12);
    repeat (5) @(negedge clk);
    cnt_rst = 1;
    seen = 0;
    repeat (12) begin @(negedge clk); if (div_pulse) seen++; end
    chk(seen == 0, "R7 no pulse in counter reset", seen, 0);
    cnt_rst = 0;
    to_pulse(n, hi);
    chk(n == cur_n - 1, "R7 restart distance", n, cur_n - 1);
    to_pulse(n, hi);
    chk(n == cur_n, "R7 period after restart", n, cur_n);
    // R8: power-down with load inside
    repeat (5) @(negedge clk);
    pdown = 1;
    seen = 0; mhi = 0;
    repeat (4) begin @(negedge clk); if (div_pulse) seen++; if (mod_ctl) mhi++; end
    psel = 2'd1; a_in = 6'd2; b_in = 12'd6; load = 1;
    @(negedge clk);
    load = 0;
    repeat (15) begin @(negedge clk); if (div_pulse) seen++; if (mod_ctl) mhi++; end
    chk(seen == 0, "R8 no pulse in power-down", seen, 0);
    chk(mhi == 0, "R8 mod_ctl low in power-down", mhi, 0);
    pdown = 0;
    to_pulse(n, hi);
    chk(n == exp_n(1, 2, 6) - 1, "R8 restart with new setting", n, exp_n(1, 2, 6) - 1);
    to_pulse(n, hi);
    chk(n == exp_n(1, 2, 6), "R8 period after power-down", n, exp_n(1, 2, 6));
    chk(hi == exp_hi(1, 2), "R8/R5 mod_ctl after power-down", hi, exp_hi(1, 2));
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule